// File: doc/BRIEF.md
# Trace Record Formatter

This block turns one captured packet header into a fixed-length trace record. Each header arrives as four 32-bit header dwords plus an optional prefix dword. When the header is accepted, the block stamps it with the value of its own free-running timestamp counter. It then streams the record out one dword per beat on a valid/ready interface, and marks the final dword with a last flag.

Two record layouts exist. The short layout is four dwords long. Its first dword packs selected fields of header dword 0 together with the low timestamp bits. The long layout is eight dwords long. It opens with an all-ones marker word and then carries the prefix, the four header dwords, a zero word and the full timestamp. Software picks the layout through a format code. The block samples that code only at the moment tracing is switched on, so a record never mixes the two layouts.

Top module: `trace_rec_fmt`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rec_valid` and `rec_last` are low. The timestamp counter restarts from 0 after reset and then increments by one every clock.
- R2: `hdr_ready` is high exactly when `trc_en` is high and no record is being emitted. A header is taken on a clock edge where `hdr_valid` and `hdr_ready` are both high, and its first beat is valid in the next cycle. When `trc_en` is low, `hdr_valid` has no effect.
- R3: The format is sampled in the cycle where `trc_en` goes from low to high. A `cfg_fmt` value of 1 selects the long (8-dword) layout, and any other value selects the short (4-dword) layout. Changes to `cfg_fmt` while `trc_en` stays high do not affect later records.
- R4: In the long layout, beat 0 is 32'hFFFF_FFFF, meaning bits 31:11 are all ones and bits 10:0 are all ones.
- R5: In the long layout, beat 1 is the prefix, beats 2 to 5 are header dwords 0 to 3 in that order, beat 6 is zero, and beat 7 is the captured timestamp.
- R6: When `pfx_valid` is low at acceptance, the prefix beat is zero whatever `pfx_dw` holds.
- R7: In the short layout, beat 0 is built from header dword 0 (`hdr_dw0`) and the timestamp as follows:
  - bits 31:30 = `hdr_dw0`[30:29]
  - bits 29:25 = `hdr_dw0`[28:24]
  - bit 24 = `hdr_dw0`[23]
  - bit 23 = `hdr_dw0`[19]
  - bit 22 = `hdr_dw0`[16]
  - bit 21 = `hdr_dw0`[13]
  - bits 20:11 = `hdr_dw0`[9:0]
  - bits 10:0 = timestamp[10:0]
- R8: In the short layout, beats 1 to 3 equal header dwords 1 to 3 unchanged.
- R9: `rec_last` is high only on the final beat of a record: beat 3 for the short layout and beat 7 for the long layout.
- R10: While `rec_valid` is high and `rec_ready` is low, `rec_data` and `rec_last` hold their values and `rec_valid` stays high.
- R11: The timestamp in a record is the counter value in the cycle before the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trc_en | input | 1 | Trace enable; its rising edge samples the format |
| cfg_fmt | input | 4 | Format code (1 = long layout, otherwise short layout) |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header can be taken |
| hdr_dw0 | input | 32 | Header dword 0 |
| hdr_dw1 | input | 32 | Header dword 1 |
| hdr_dw2 | input | 32 | Header dword 2 |
| hdr_dw3 | input | 32 | Header dword 3 |
| pfx_valid | input | 1 | Prefix dword present |
| pfx_dw | input | 32 | Prefix dword |
| rec_valid | output | 1 | Record beat valid |
| rec_ready | input | 1 | Sink takes the beat |
| rec_data | output | 32 | Record dword |
| rec_last | output | 1 | Final beat of a record |

## Verification
The test headers fall into a few groups, and each group separates a different mistake:
- Headers whose dword 0 is all ones, alternating bits, or single isolated bits show whether each packed field of the short first word is taken from the right source bit.
- Long-layout records with and without a prefix, where the prefix bus carries non-zero data in both cases, separate prefix gating from plain copying.
- Records that are stalled on alternate beats show whether the output holds under backpressure.
- Format codes of 1, 0 and 5, along with format changes made while tracing stays on, separate the sampling on the rising edge of `trc_en` from plain decoding of `cfg_fmt`.
- Timestamps are compared against a counter in the bench, which exposes an off-by-one in the capture cycle.

// File: rtl/trfmt_pkg.sv
package trfmt_pkg;

    localparam int WORD_W = 32;
    localparam int SHORT_TS_W = 11;
    localparam logic [3:0] CODE_LONG = 4'd1;
    localparam logic [WORD_W-1:0] LONG_MARK = {21'h1f_ffff, 11'h7ff};

    typedef enum logic {
        FMT_SHORT = 1'b0,
        FMT_LONG  = 1'b1
    } rec_fmt_e;

    typedef struct packed {
        rec_fmt_e                   fmt;
        logic [WORD_W-1:0]          pfx;
        logic [3:0][WORD_W-1:0]     hdr;
        logic [WORD_W-1:0]          ts;
    } cap_t;

    function automatic rec_fmt_e decode_fmt(input logic [3:0] code);
        return (code == CODE_LONG) ? FMT_LONG : FMT_SHORT;
    endfunction

    function automatic logic [2:0] final_beat(input rec_fmt_e f);
        return (f == FMT_LONG) ? 3'd7 : 3'd3;
    endfunction

    function automatic logic [WORD_W-1:0] pack_short_head(
        input logic [WORD_W-1:0] h0,
        input logic [WORD_W-1:0] ts
    );
        return {h0[30:29], h0[28:24], h0[23], h0[19], h0[16], h0[13],
                h0[9:0], ts[SHORT_TS_W-1:0]};
    endfunction

endpackage

// File: rtl/trfmt_tstamp.sv
module trfmt_tstamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] ts_now
);
    always_ff @(posedge clk) begin
        if (rst) ts_now <= '0;
        else     ts_now <= ts_now + 1'b1;
    end
endmodule

// File: rtl/trfmt_capture.sv
module trfmt_capture
    import trfmt_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   trc_en,
    input  logic [3:0]             cfg_fmt,
    input  logic                   accept,
    input  logic [3:0][WORD_W-1:0] hdr_in,
    input  logic                   pfx_valid,
    input  logic [WORD_W-1:0]      pfx_in,
    input  logic [TS_W-1:0]        ts_now,
    output cap_t                   cap_q
);
    logic     en_q;
    rec_fmt_e fmt_q;
    rec_fmt_e fmt_eff;
    logic     en_rise;

    assign en_rise = trc_en && !en_q;
    // A header taken in the enable cycle already sees the new format.
    assign fmt_eff = en_rise ? decode_fmt(cfg_fmt) : fmt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            fmt_q <= FMT_SHORT;
        end else begin
            en_q <= trc_en;
            if (en_rise) fmt_q <= decode_fmt(cfg_fmt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else if (accept) begin
            cap_q.fmt <= fmt_eff;
            cap_q.pfx <= pfx_valid ? pfx_in : '0;
            cap_q.hdr <= hdr_in;
            cap_q.ts  <= WORD_W'(ts_now);
        end
    end
endmodule

// File: rtl/trfmt_beat_seq.sv
module trfmt_beat_seq
    import trfmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  logic     out_ready,
    input  rec_fmt_e fmt,
    output logic     busy,
    output logic [2:0] beat,
    output logic     last
);
    logic at_end;

    assign at_end = (beat == final_beat(fmt));
    assign last   = busy && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            beat <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            beat <= '0;
        end else if (busy && out_ready) begin
            if (at_end) begin
                busy <= 1'b0;
                beat <= '0;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end
endmodule

// File: rtl/trfmt_word_sel.sv
module trfmt_word_sel
    import trfmt_pkg::*;
(
    input  cap_t              cap,
    input  logic [2:0]        beat,
    output logic [WORD_W-1:0] word
);
    logic [7:0][WORD_W-1:0] long_w;
    logic [3:0][WORD_W-1:0] short_w;

    assign long_w[0] = LONG_MARK;
    assign long_w[1] = cap.pfx;
    assign long_w[6] = '0;
    assign long_w[7] = cap.ts;
    assign short_w[0] = pack_short_head(cap.hdr[0], cap.ts);

    for (genvar g = 0; g < 4; g++) begin : g_long_hdr
        assign long_w[g+2] = cap.hdr[g];
    end
    for (genvar g = 1; g < 4; g++) begin : g_short_hdr
        assign short_w[g] = cap.hdr[g];
    end

    always_comb begin
        if (cap.fmt == FMT_LONG) word = long_w[beat];
        else                     word = short_w[beat[1:0]];
    end
endmodule

// File: rtl/trace_rec_fmt.sv
module trace_rec_fmt
    import trfmt_pkg::*;
#(
    parameter int TS_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        trc_en,
    input  logic [3:0]  cfg_fmt,
    input  logic        hdr_valid,
    output logic        hdr_ready,
    input  logic [31:0] hdr_dw0,
    input  logic [31:0] hdr_dw1,
    input  logic [31:0] hdr_dw2,
    input  logic [31:0] hdr_dw3,
    input  logic        pfx_valid,
    input  logic [31:0] pfx_dw,
    output logic        rec_valid,
    input  logic        rec_ready,
    output logic [31:0] rec_data,
    output logic        rec_last
);
    if (TS_W < SHORT_TS_W || TS_W > WORD_W) begin : g_bad_ts
        initial $error("TS_W must lie between 11 and 32");
    end

    logic [TS_W-1:0]        ts_now;
    logic                   accept;
    logic                   busy;
    logic [2:0]             beat;
    logic                   rec_is_long;
    logic [3:0][WORD_W-1:0] hdr_in;
    cap_t                   cap_q;

    assign hdr_in      = {hdr_dw3, hdr_dw2, hdr_dw1, hdr_dw0};
    assign hdr_ready   = trc_en && !busy;
    assign accept      = hdr_valid && hdr_ready;
    assign rec_valid   = busy;
    assign rec_is_long = (cap_q.fmt == FMT_LONG);

    trfmt_tstamp #(.TS_W(TS_W)) u_tstamp (
        .clk(clk), .rst(rst), .ts_now(ts_now)
    );

    trfmt_capture #(.TS_W(TS_W)) u_capture (
        .clk(clk), .rst(rst), .trc_en(trc_en), .cfg_fmt(cfg_fmt),
        .accept(accept), .hdr_in(hdr_in), .pfx_valid(pfx_valid),
        .pfx_in(pfx_dw), .ts_now(ts_now), .cap_q(cap_q)
    );

    trfmt_beat_seq u_seq (
        .clk(clk), .rst(rst), .accept(accept), .out_ready(rec_ready),
        .fmt(cap_q.fmt), .busy(busy), .beat(beat), .last(rec_last)
    );

    trfmt_word_sel u_sel (
        .cap(cap_q), .beat(beat), .word(rec_data)
    );
endmodule

// File: rtl/trfmt_chk.sv
module trfmt_chk (
    input logic        clk,
    input logic        rst,
    input logic        hdr_valid,
    input logic        hdr_ready,
    input logic        rec_valid,
    input logic        rec_ready,
    input logic [31:0] rec_data,
    input logic        rec_last,
    input logic        rec_is_long
);
    logic [2:0] seen_beat;

    always_ff @(posedge clk) begin
        if (rst)                         seen_beat <= '0;
        else if (rec_valid && rec_ready) seen_beat <= rec_last ? 3'd0 : seen_beat + 1'b1;
    end

    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> !hdr_ready); // R2
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_ready) |=> (rec_valid && seen_beat == 3'd0)); // R2
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_data) && $stable(rec_last))); // R10
    AST_LAST_POSITION: assert property (@(posedge clk) disable iff (rst)
        rec_last |-> (rec_valid && seen_beat == (rec_is_long ? 3'd7 : 3'd3))); // R9
    AST_LONG_MARKER: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_is_long && seen_beat == 3'd0) |-> (rec_data == 32'hFFFF_FFFF)); // R4
    AST_LONG_ZERO_WORD: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_is_long && seen_beat == 3'd6) |-> (rec_data == 32'h0)); // R5
endmodule

bind trace_rec_fmt trfmt_chk u_chk (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
    .rec_last(rec_last), .rec_is_long(rec_is_long)
);

// File: tb/trace_rec_fmt_tb.sv
module trace_rec_fmt_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trc_en = 1'b0;
    logic [3:0]  cfg_fmt = '0;
    logic        hdr_valid = 1'b0;
    logic        hdr_ready;
    logic [31:0] hdr_dw0 = '0, hdr_dw1 = '0, hdr_dw2 = '0, hdr_dw3 = '0;
    logic        pfx_valid = 1'b0;
    logic [31:0] pfx_dw = '0;
    logic        rec_valid;
    logic        rec_ready = 1'b0;
    logic [31:0] rec_data;
    logic        rec_last;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    logic [31:0] ref_ts;

    always #10 clk = ~clk;

    // Bench model of the timestamp counter (R1, R11)
    always_ff @(posedge clk) begin
        if (rst) ref_ts <= '0;
        else     ref_ts <= ref_ts + 1'b1;
    end

    trace_rec_fmt u_dut (
        .clk(clk), .rst(rst), .trc_en(trc_en), .cfg_fmt(cfg_fmt),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
        .hdr_dw0(hdr_dw0), .hdr_dw1(hdr_dw1), .hdr_dw2(hdr_dw2), .hdr_dw3(hdr_dw3),
        .pfx_valid(pfx_valid), .pfx_dw(pfx_dw),
        .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_data(rec_data), .rec_last(rec_last)
    );

    // Vector: {fmt code[3:0], pfx_valid, pfx[31:0], h0, h1, h2, h3}
    localparam int NV = 6;
    localparam logic [164:0] VEC [NV] = '{
        {4'd0, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1111_2222, 32'h3333_4444, 32'h5555_6666},
        {4'd0, 1'b1, 32'hDEAD_BEEF, 32'hAAAA_AAAA, 32'h0102_0304, 32'h0506_0708, 32'h090A_0B0C},
        {4'd1, 1'b1, 32'hCAFE_F00D, 32'h6000_0001, 32'h0F1E_0001, 32'h0400_0000, 32'h4000_8102},
        {4'd1, 1'b0, 32'h1234_5678, 32'h5555_5555, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'hFFFF_0000},
        {4'd5, 1'b1, 32'h7777_7777, 32'h0089_2201, 32'h8000_0000, 32'h0000_0001, 32'h00FF_FF00},
        {4'd1, 1'b1, 32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic start_trace(input logic [3:0] code);
        @(negedge clk);
        trc_en = 1'b0;
        cfg_fmt = code;
        @(negedge clk);
        trc_en = 1'b1;
        @(negedge clk);
    endtask

    // Offers one header, returns the timestamp expected in its record (R11)
    task automatic send(input logic [164:0] v, output logic [31:0] ts);
        pfx_valid = v[160];
        pfx_dw    = v[159:128];
        hdr_dw0   = v[127:96];
        hdr_dw1   = v[95:64];
        hdr_dw2   = v[63:32];
        hdr_dw3   = v[31:0];
        hdr_valid = 1'b1;
        while (!hdr_ready) @(negedge clk);
        ts = ref_ts;
        @(negedge clk);
        hdr_valid = 1'b0;
        pfx_dw = 32'hBAD0_BAD0;
    endtask

    task automatic collect(input logic [164:0] v, input bit is_long,
                           input logic [31:0] ts, input bit stall);
        logic [31:0] e [8];
        logic [31:0] h0;
        int n;
        h0 = v[127:96];
        if (is_long) begin
            n = 8;
            e[0] = 32'hFFFF_FFFF;                     // R4
            e[1] = v[160] ? v[159:128] : 32'h0;        // R5, R6
            e[2] = v[127:96]; e[3] = v[95:64];
            e[4] = v[63:32];  e[5] = v[31:0];
            e[6] = 32'h0;     e[7] = ts;               // R11
        end else begin
            n = 4;
            e[0] = {h0[30:29], h0[28:24], h0[23], h0[19], h0[16], h0[13],
                    h0[9:0], ts[10:0]};                // R7
            e[1] = v[95:64]; e[2] = v[63:32]; e[3] = v[31:0]; // R8
            for (int k = 4; k < 8; k++) e[k] = '0;
        end
        for (int b = 0; b < n; b++) begin
            if (stall && (b % 2 == 0)) begin
                rec_ready = 1'b0;
                @(negedge clk);
                check(rec_valid && rec_data == e[b], "R10 held beat", rec_data, e[b]);
            end
            rec_ready = 1'b1;
            check(rec_valid === 1'b1, "R2 beat valid", {31'b0, rec_valid}, 32'd1);
            check(rec_data === e[b], is_long ? "R5 long beat" : "R7/R8 short beat",
                  rec_data, e[b]);
            check(rec_last === (b == n - 1), "R9 last flag", {31'b0, rec_last},
                  {31'b0, (b == n - 1)});
            check(hdr_ready === 1'b0, "R2 ready low while busy", {31'b0, hdr_ready}, 32'd0);
            @(negedge clk);
        end
        check(rec_valid === 1'b0, "R9 record ends", {31'b0, rec_valid}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] ts;
        repeat (3) @(negedge clk);
        check(rec_valid === 1'b0 && rec_last === 1'b0, "R1 reset outputs",
              {30'b0, rec_valid, rec_last}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(rec_valid === 1'b0 && rec_last === 1'b0, "R1 after reset",
              {30'b0, rec_valid, rec_last}, 32'd0);
        check(hdr_ready === 1'b0, "R2 ready low when disabled", {31'b0, hdr_ready}, 32'd0);
        check(ref_ts == 32'd1, "R1 counter model", ref_ts, 32'd1);

        // R2: headers ignored while tracing is off
        hdr_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(rec_valid === 1'b0 && hdr_ready === 1'b0, "R2 disabled ignores header",
                  {30'b0, rec_valid, hdr_ready}, 32'd0);
        end
        hdr_valid = 1'b0;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            start_trace(VEC[i][164:161]);
            check(hdr_ready === 1'b1, "R2 ready when idle", {31'b0, hdr_ready}, 32'd1);
            send(VEC[i], ts);
            collect(VEC[i], VEC[i][164:161] == 4'd1, ts, (i % 2) == 1);
            check(hdr_ready === 1'b1, "R2 ready after record", {31'b0, hdr_ready}, 32'd1);
        end

        // R3: format change while enabled is ignored (short stays)
        start_trace(4'd0);
        cfg_fmt = 4'd1;
        @(negedge clk);
        send(VEC[2], ts);
        collect(VEC[2], 1'b0, ts, 1'b0);

        // R3: long sampled at rise, then cfg goes to 0 while enabled
        start_trace(4'd1);
        cfg_fmt = 4'd0;
        @(negedge clk);
        send(VEC[0], ts);
        collect(VEC[0], 1'b1, ts, 1'b1);

        // R2: two records back to back with header held valid
        send(VEC[3], ts);
        collect(VEC[3], 1'b1, ts, 1'b0);
        send(VEC[1], ts);
        collect(VEC[1], 1'b1, ts, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule